// File: doc/BRIEF.md
# Reference Count Semaphore Unit

This block guards shared buffers that one producer fills and several consumers read in place, without copying. Each tracked entry holds a small count instead of a single full/empty flag. When the producer is granted a write to an entry, the count is loaded with that entry's configured fan-out, the number of consumers that will read it. Each consumer may fire on an entry only while its count is nonzero, and every fire lowers the count by one. The consumer that brings the count from one to zero is the last reader, so it is told that it may also overwrite the data in place.

Requests are never rejected. A consumer that finds a zero count and a producer that finds a nonzero count are stalled, and they are granted in the first cycle in which the count allows it. Grants are decided combinationally in the cycle of the request, and the count changes at the following clock edge. A parameter chooses whether one count covers a whole buffer or each element of a buffer has its own count, so that elements can be read before the whole buffer is filled. Bus arbitration and the data storage are left to the surrounding logic.

Top module: `rcsem_unit`

## Requirements
- R1: After reset every count is zero, so a consumer request to any entry is stalled and a producer request is granted.
- R2: A granted producer write loads the entry's count with the entry's configured fan-out at the next clock edge.
- R3: A consumer is granted only while its entry's count is nonzero; otherwise it is stalled, and the count is unchanged in any cycle without a grant.
- R4: Each consumer grant lowers its entry's count by exactly one, so after fan-out grants further requests to that entry stall.
- R5: The in-place flag of a consumer is high exactly when it is granted on a count of one.
- R6: A producer request to an entry whose count is nonzero is stalled and is granted in the first cycle the count is zero.
- R7: In a cycle where the producer is granted on an entry, every consumer requesting that same entry is stalled.
- R8: When several consumers request one entry in the same cycle, only the lowest-numbered port can be granted; the others stall.
- R9: Consumers requesting different entries in the same cycle are each granted independently and each decrement only their own entry.
- R10: A configuration write with `cfg_we` high stores the fan-out for the addressed entry at the next edge; a producer grant on an entry with fan-out zero leaves its count at zero.
- R11: An address is {buffer, element} with the element in the low `ELEM_BITS` bits; with `TRACK_ELEM`=1 each element has its own count, with `TRACK_ELEM`=0 all elements of a buffer share one count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Fan-out configuration write enable |
| cfg_addr | input | AW | Address whose entry receives the fan-out |
| cfg_fanout | input | CNT_W | Number of consumers for that entry |
| prod_req | input | 1 | Producer write request |
| prod_addr | input | AW | Producer target address |
| prod_grant | output | 1 | Producer may write this cycle |
| prod_stall | output | 1 | Producer must hold its request |
| cons_req | input | NCONS | Consumer fire requests, one per port |
| cons_addr | input | NCONS x AW | Consumer target addresses |
| cons_grant | output | NCONS | Consumer may fire this cycle |
| cons_stall | output | NCONS | Consumer must hold its request |
| cons_sole | output | NCONS | Granted consumer is the last reader and may write in place |

## Verification
The bench builds two copies with four buffers of four elements, three consumer ports and a three-bit count: one with per-element counts and one with a count per buffer. The per-element copy brings within reach the separation of neighbouring elements, same-entry contention among three ports, fan-outs of zero, one, two and three, and reconfiguration between uses. The per-buffer copy shows a producer write to one element releasing a consumer on a different element of the same buffer.

// File: rtl/rcsem_pkg.sv
package rcsem_pkg;

   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_LOAD = 2'd1,
      ACT_DEC  = 2'd2
   } rcsem_act_e;

endpackage

// File: rtl/rcsem_map.sv
module rcsem_map #(
   parameter int AW         = 4,
   parameter int ELEM_BITS  = 2,
   parameter int TRACK_ELEM = 1,
   parameter int EW         = 4
) (
   input  logic [AW-1:0] addr,
   output logic [EW-1:0] ent
);

   generate
      if (TRACK_ELEM != 0) begin : g_elem
         assign ent = addr;
      end else begin : g_buf
         logic unused_elem;
         assign ent         = addr[AW-1:ELEM_BITS];
         assign unused_elem = ^addr[ELEM_BITS-1:0];
      end
   endgenerate

endmodule

// File: rtl/rcsem_cfg.sv
module rcsem_cfg #(
   parameter int NENT  = 16,
   parameter int EW    = 4,
   parameter int CNT_W = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [EW-1:0]              wr_ent,
   input  logic [CNT_W-1:0]           wr_val,
   output logic [NENT-1:0][CNT_W-1:0] fan
);

   generate
      for (genvar e = 0; e < NENT; e++) begin : g_ent
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               fan[e] <= '0;
            end else if (wr_en && (wr_ent == EW'(e))) begin
               fan[e] <= wr_val;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/rcsem_arb.sv
module rcsem_arb #(
   parameter int NCONS = 3,
   parameter int EW    = 4
) (
   input  logic                       prod_grant,
   input  logic [EW-1:0]              prod_ent,
   input  logic [NCONS-1:0]           cons_req,
   input  logic [NCONS-1:0][EW-1:0]   cons_ent,
   input  logic [NCONS-1:0]           cons_nz,
   output logic [NCONS-1:0]           cons_grant
);

   generate
      for (genvar i = 0; i < NCONS; i++) begin : g_port
         logic shadowed;
         always_comb begin
            shadowed = 1'b0;
            for (int j = 0; j < i; j++) begin
               if (cons_req[j] && (cons_ent[j] == cons_ent[i])) begin
                  shadowed = 1'b1;
               end
            end
         end
         assign cons_grant[i] = cons_req[i] && cons_nz[i] && !shadowed &&
                                !(prod_grant && (prod_ent == cons_ent[i]));
      end
   endgenerate

endmodule

// File: rtl/rcsem_cnt.sv
module rcsem_cnt
   import rcsem_pkg::*;
#(
   parameter int NENT  = 16,
   parameter int EW    = 4,
   parameter int CNT_W = 3,
   parameter int NCONS = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       prod_grant,
   input  logic [EW-1:0]              prod_ent,
   input  logic [NCONS-1:0]           cons_grant,
   input  logic [NCONS-1:0][EW-1:0]   cons_ent,
   input  logic [NENT-1:0][CNT_W-1:0] fan,
   output logic [NENT-1:0][CNT_W-1:0] cnt
);

   generate
      for (genvar e = 0; e < NENT; e++) begin : g_ent
         rcsem_act_e act;
         logic       hit_dec;

         always_comb begin
            hit_dec = 1'b0;
            for (int i = 0; i < NCONS; i++) begin
               if (cons_grant[i] && (cons_ent[i] == EW'(e))) begin
                  hit_dec = 1'b1;
               end
            end
            if (prod_grant && (prod_ent == EW'(e))) begin
               act = ACT_LOAD;
            end else if (hit_dec) begin
               act = ACT_DEC;
            end else begin
               act = ACT_HOLD;
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt[e] <= '0;
            end else begin
               case (act)
                  ACT_LOAD: cnt[e] <= fan[e];
                  ACT_DEC:  cnt[e] <= cnt[e] - CNT_W'(1);
                  default:  cnt[e] <= cnt[e];
               endcase
            end
         end
      end
   endgenerate

endmodule

// File: rtl/rcsem_unit.sv
module rcsem_unit #(
   parameter int NBUF       = 4,
   parameter int ELEM_BITS  = 2,
   parameter int TRACK_ELEM = 1,
   parameter int NCONS      = 3,
   parameter int CNT_W      = 3,
   localparam int BUF_BITS  = $clog2(NBUF),
   localparam int AW        = BUF_BITS + ELEM_BITS,
   localparam int EW        = (TRACK_ELEM != 0) ? AW : BUF_BITS,
   localparam int NENT      = 1 << EW
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [AW-1:0]            cfg_addr,
   input  logic [CNT_W-1:0]         cfg_fanout,
   input  logic                     prod_req,
   input  logic [AW-1:0]            prod_addr,
   output logic                     prod_grant,
   output logic                     prod_stall,
   input  logic [NCONS-1:0]         cons_req,
   input  logic [NCONS-1:0][AW-1:0] cons_addr,
   output logic [NCONS-1:0]         cons_grant,
   output logic [NCONS-1:0]         cons_stall,
   output logic [NCONS-1:0]         cons_sole
);

   generate
      if (NBUF < 2 || (NBUF & (NBUF - 1)) != 0) begin : g_bad_nbuf
         $error("rcsem_unit: NBUF must be a power of two of at least 2");
      end
      if (ELEM_BITS < 1) begin : g_bad_elem
         $error("rcsem_unit: ELEM_BITS must be at least 1");
      end
      if (NCONS < 1 || CNT_W < 1) begin : g_bad_cons
         $error("rcsem_unit: NCONS and CNT_W must be at least 1");
      end
      if (NCONS >= (1 << CNT_W)) begin : g_bad_cnt
         $error("rcsem_unit: CNT_W too narrow to count NCONS readers");
      end
   endgenerate

   logic [EW-1:0]              cfg_ent;
   logic [EW-1:0]              prod_ent;
   logic [NCONS-1:0][EW-1:0]   cons_ent;
   logic [NENT-1:0][CNT_W-1:0] fan_q;
   logic [NENT-1:0][CNT_W-1:0] cnt_q;
   logic [NCONS-1:0]           cons_nz;

   rcsem_map #(.AW(AW), .ELEM_BITS(ELEM_BITS), .TRACK_ELEM(TRACK_ELEM), .EW(EW))
      u_map_cfg (.addr(cfg_addr), .ent(cfg_ent));

   rcsem_map #(.AW(AW), .ELEM_BITS(ELEM_BITS), .TRACK_ELEM(TRACK_ELEM), .EW(EW))
      u_map_prod (.addr(prod_addr), .ent(prod_ent));

   generate
      for (genvar i = 0; i < NCONS; i++) begin : g_cons
         rcsem_map #(.AW(AW), .ELEM_BITS(ELEM_BITS), .TRACK_ELEM(TRACK_ELEM), .EW(EW))
            u_map (.addr(cons_addr[i]), .ent(cons_ent[i]));
         assign cons_nz[i]    = (cnt_q[cons_ent[i]] != '0);
         assign cons_sole[i]  = cons_grant[i] && (cnt_q[cons_ent[i]] == CNT_W'(1));
         assign cons_stall[i] = cons_req[i] && !cons_grant[i];
      end
   endgenerate

   assign prod_grant = prod_req && (cnt_q[prod_ent] == '0);
   assign prod_stall = prod_req && !prod_grant;

   rcsem_cfg #(.NENT(NENT), .EW(EW), .CNT_W(CNT_W)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_we),
      .wr_ent (cfg_ent),
      .wr_val (cfg_fanout),
      .fan    (fan_q)
   );

   rcsem_arb #(.NCONS(NCONS), .EW(EW)) u_arb (
      .prod_grant (prod_grant),
      .prod_ent   (prod_ent),
      .cons_req   (cons_req),
      .cons_ent   (cons_ent),
      .cons_nz    (cons_nz),
      .cons_grant (cons_grant)
   );

   rcsem_cnt #(.NENT(NENT), .EW(EW), .CNT_W(CNT_W), .NCONS(NCONS)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .prod_grant (prod_grant),
      .prod_ent   (prod_ent),
      .cons_grant (cons_grant),
      .cons_ent   (cons_ent),
      .fan        (fan_q),
      .cnt        (cnt_q)
   );

endmodule

// File: rtl/rcsem_unit_chk.sv
module rcsem_unit_chk #(
   parameter int NENT  = 16,
   parameter int EW    = 4,
   parameter int CNT_W = 3,
   parameter int NCONS = 3
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       prod_grant,
   input logic [EW-1:0]              prod_ent,
   input logic [NCONS-1:0]           cons_grant,
   input logic [NCONS-1:0][EW-1:0]   cons_ent,
   input logic [NCONS-1:0]           cons_sole,
   input logic [NENT-1:0][CNT_W-1:0] fan,
   input logic [NENT-1:0][CNT_W-1:0] cnt
);

   AST_LOAD_FANOUT: assert property (@(posedge clk) disable iff (!rst_n)
      prod_grant |=> cnt[$past(prod_ent)] == $past(fan[prod_ent])); // R2

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!prod_grant && cons_grant == '0) |=> $stable(cnt)); // R3

   generate
      for (genvar i = 0; i < NCONS; i++) begin : g_port
         AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            cons_grant[i] |-> cnt[cons_ent[i]] != '0); // R3

         AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
            cons_grant[i] |=> cnt[$past(cons_ent[i])] ==
                              CNT_W'($past(cnt[cons_ent[i]]) - CNT_W'(1))); // R4

         AST_SOLE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
            cons_sole[i] |=> cnt[$past(cons_ent[i])] == '0); // R5

         AST_NO_LOAD_RACE: assert property (@(posedge clk) disable iff (!rst_n)
            (prod_grant && cons_grant[i]) |-> prod_ent != cons_ent[i]); // R7

         for (genvar j = i + 1; j < NCONS; j++) begin : g_pair
            AST_ONE_PER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
               (cons_grant[i] && cons_grant[j]) |-> cons_ent[i] != cons_ent[j]); // R8
         end
      end
   endgenerate

endmodule

bind rcsem_unit rcsem_unit_chk #(.NENT(NENT), .EW(EW), .CNT_W(CNT_W), .NCONS(NCONS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .prod_grant (prod_grant),
   .prod_ent   (prod_ent),
   .cons_grant (cons_grant),
   .cons_ent   (cons_ent),
   .cons_sole  (cons_sole),
   .fan        (fan_q),
   .cnt        (cnt_q)
);

// File: tb/rcsem_unit_test.sv
`timescale 1ns/1ps
module rcsem_unit_test;

   localparam int NC = 3;
   localparam int AW = 4;
   localparam int CW = 3;

   typedef struct {
      logic          pg;
      logic [NC-1:0] cg;
      logic [NC-1:0] cs;
      string         tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic                  cfg_we = 1'b0;
   logic [AW-1:0]         cfg_addr = '0;
   logic [CW-1:0]         cfg_fanout = '0;
   logic                  prod_req = 1'b0;
   logic [AW-1:0]         prod_addr = '0;
   logic [NC-1:0]         cons_req = '0;
   logic [NC-1:0][AW-1:0] cons_addr = '0;
   logic                  prod_grant, prod_stall;
   logic [NC-1:0]         cons_grant, cons_stall, cons_sole;

   logic                  b_cfg_we = 1'b0;
   logic [AW-1:0]         b_cfg_addr = '0;
   logic [CW-1:0]         b_cfg_fanout = '0;
   logic                  b_prod_req = 1'b0;
   logic [AW-1:0]         b_prod_addr = '0;
   logic [NC-1:0]         b_cons_req = '0;
   logic [NC-1:0][AW-1:0] b_cons_addr = '0;
   logic                  b_prod_grant, b_prod_stall;
   logic [NC-1:0]         b_cons_grant, b_cons_stall, b_cons_sole;

   rcsem_unit #(.NBUF(4), .ELEM_BITS(2), .TRACK_ELEM(1), .NCONS(NC), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_fanout(cfg_fanout), .prod_req(prod_req), .prod_addr(prod_addr),
      .prod_grant(prod_grant), .prod_stall(prod_stall), .cons_req(cons_req),
      .cons_addr(cons_addr), .cons_grant(cons_grant), .cons_stall(cons_stall),
      .cons_sole(cons_sole));

   rcsem_unit #(.NBUF(4), .ELEM_BITS(2), .TRACK_ELEM(0), .NCONS(NC), .CNT_W(CW)) uut_buf (
      .clk(clk), .rst_n(rst_n), .cfg_we(b_cfg_we), .cfg_addr(b_cfg_addr),
      .cfg_fanout(b_cfg_fanout), .prod_req(b_prod_req), .prod_addr(b_prod_addr),
      .prod_grant(b_prod_grant), .prod_stall(b_prod_stall), .cons_req(b_cons_req),
      .cons_addr(b_cons_addr), .cons_grant(b_cons_grant), .cons_stall(b_cons_stall),
      .cons_sole(b_cons_sole));

   int   n_checks = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   exp_t sb[$];

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // monitor: pops one expected item per cycle, sampled 1 ns after the falling edge
   always @(negedge clk) begin
      #1;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check(prod_grant == e.pg && prod_stall == (prod_req && !e.pg), e.tag, "prod",
               {6'd0, prod_stall, prod_grant}, {6'd0, prod_req && !e.pg, e.pg});
         check(cons_grant == e.cg && cons_stall == (cons_req & ~e.cg), e.tag, "cons grant",
               {5'd0, cons_grant}, {5'd0, e.cg});
         check(cons_sole == e.cs, e.tag, "cons sole", {5'd0, cons_sole}, {5'd0, e.cs});
      end
   end

   // driver: one request cycle on uut, expectation pushed to the scoreboard
   task automatic cyc(input logic pr, input logic [AW-1:0] pa, input logic [NC-1:0] cr,
                      input logic [AW-1:0] a0, a1, a2, input logic epg,
                      input logic [NC-1:0] ecg, ecs, input string tag);
      exp_t e;
      @(negedge clk);
      cfg_we    = 1'b0;
      prod_req  = pr;
      prod_addr = pa;
      cons_req  = cr;
      cons_addr = {a2, a1, a0};
      e.pg = epg; e.cg = ecg; e.cs = ecs; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic cfg(input logic [AW-1:0] a, input logic [CW-1:0] v, input string tag);
      exp_t e;
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_fanout = v;
      prod_req = 1'b0; cons_req = '0;
      e.pg = 1'b0; e.cg = '0; e.cs = '0; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic bcyc(input logic cw, input logic pr, input logic cr0, input logic [AW-1:0] a,
                       input logic epg, input logic ecg, input logic ecs, input string tag);
      @(negedge clk);
      b_cfg_we = cw; b_cfg_addr = a; b_cfg_fanout = 3'd1;
      b_prod_req = pr; b_prod_addr = a;
      b_cons_req = {2'b00, cr0}; b_cons_addr = {4'd0, 4'd0, a};
      #1;
      if (!cw) begin
         check(b_prod_grant == epg, tag, "buf prod", {7'd0, b_prod_grant}, {7'd0, epg});
         check(b_cons_grant[0] == ecg && b_cons_sole[0] == ecs, tag, "buf cons",
               {6'd0, b_cons_sole[0], b_cons_grant[0]}, {6'd0, ecs, ecg});
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: fresh counts are zero
      cyc(0, 0, 3'b001, 0, 0, 0, 0, 3'b000, 3'b000, "R1");
      cfg(4'd0, 3'd2, "R10");
      cfg(4'd1, 3'd1, "R10");
      cfg(4'd5, 3'd3, "R10");
      cfg(4'd2, 3'd0, "R10");
      cyc(0, 0, 3'b001, 0, 0, 0, 0, 3'b000, 3'b000, "R3");
      cyc(1, 0, 3'b001, 0, 0, 0, 1, 3'b000, 3'b000, "R7");
      cyc(0, 0, 3'b011, 0, 0, 0, 0, 3'b001, 3'b000, "R3 R8");
      cyc(0, 0, 3'b010, 0, 0, 0, 0, 3'b010, 3'b010, "R5");
      cyc(0, 0, 3'b100, 0, 0, 0, 0, 3'b000, 3'b000, "R4");
      cyc(1, 0, 3'b000, 0, 0, 0, 1, 3'b000, 3'b000, "R2");
      cyc(1, 0, 3'b000, 0, 0, 0, 0, 3'b000, 3'b000, "R6");
      cyc(1, 0, 3'b101, 0, 0, 0, 0, 3'b001, 3'b000, "R6 R8");
      cyc(1, 0, 3'b100, 0, 0, 0, 0, 3'b100, 3'b100, "R5 R6");
      cyc(1, 0, 3'b000, 0, 0, 0, 1, 3'b000, 3'b000, "R6");
      cyc(1, 5, 3'b000, 0, 0, 0, 1, 3'b000, 3'b000, "R2");
      cyc(0, 0, 3'b111, 5, 0, 1, 0, 3'b011, 3'b000, "R9");
      cyc(0, 0, 3'b011, 4, 5, 0, 0, 3'b010, 3'b000, "R11");
      cyc(0, 0, 3'b010, 0, 5, 0, 0, 3'b010, 3'b010, "R4 R11");
      cyc(1, 2, 3'b000, 0, 0, 0, 1, 3'b000, 3'b000, "R10");
      cyc(0, 0, 3'b001, 2, 0, 0, 0, 3'b000, 3'b000, "R10");
      cfg(4'd1, 3'd2, "R10");
      cyc(1, 1, 3'b000, 0, 0, 0, 1, 3'b000, 3'b000, "R10");
      cyc(0, 0, 3'b100, 0, 0, 1, 0, 3'b100, 3'b000, "R10");
      cyc(0, 0, 3'b010, 0, 0, 0, 0, 3'b010, 3'b010, "R4");
      cyc(0, 0, 3'b111, 0, 1, 5, 0, 3'b010, 3'b010, "R4 R5");
      cyc(0, 0, 3'b000, 0, 0, 0, 0, 3'b000, 3'b000, "idle");
      // R11: one shared count per buffer in uut_buf
      bcyc(1, 0, 0, 4'd4, 0, 0, 0, "R11");
      bcyc(0, 0, 1, 4'd6, 0, 0, 0, "R11");
      bcyc(0, 1, 0, 4'd4, 1, 0, 0, "R11");
      bcyc(0, 0, 1, 4'd7, 0, 1, 1, "R11");
      bcyc(0, 0, 1, 4'd5, 0, 0, 0, "R11");
      @(negedge clk);
      cons_req = '0; prod_req = 1'b0; b_cons_req = '0;
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule